// File: doc/BRIEF.md
# Packed SIMD Saturating and Averaging Adder

This block runs one add-type operation across every lane of two 128-bit operand vectors, `ws_i` and `wt_i`. A two-bit format code sets the lane width to 8, 16, 32 or 64 bits. Lanes never exchange carries. The operation set covers several kinds of arithmetic:

- wrapping add and subtract;
- sums of magnitudes, in wrapping and clamped forms;
- signed and unsigned clamped add and subtract;
- two mixed-signedness clamped subtracts;
- truncating and rounding means that cannot overflow;
- absolute differences.

A caller raises `start_i` for one cycle with the opcode, format and operands. The lane results come back on `res_o` one clock later, qualified by `valid_o`. An opcode outside the defined set yields an all-zero vector and raises `illegal_o`.

Each lane works internally on operands widened by two guard bits. Overflow is therefore detected exactly, before the lane result is clamped back to its own width. All four lane widths are computed in parallel, and the format code selects one set of results ahead of the output register.

Top module: `vsat_adder`

## Requirements
- R1: Format code 0, 1, 2 and 3 select 8, 16, 32 and 64-bit lanes. Opcode 0 is the wrapping sum ws+wt and opcode 1 is the wrapping difference ws-wt. No carry crosses a lane boundary.
- R2: Opcode 2 adds the magnitudes |ws|+|wt| and wraps, so the magnitude of the most negative value counts as 2^(W-1). Opcode 3 adds the same magnitudes but clamps any sum above the signed maximum to that maximum.
- R3: Opcode 4 is a signed clamped add and opcode 6 is a signed clamped subtract. A result above the signed maximum gives the maximum; a result below the signed minimum gives the minimum.
- R4: Opcode 5 is an unsigned clamped add, and a carry out gives all ones. Opcode 7 is an unsigned clamped subtract, and it gives zero when ws is below wt.
- R5: Opcode 8 reads ws as unsigned and wt as signed, then forms ws-wt. A negative result clamps to zero, and a result above all ones clamps to all ones.
- R6: Opcode 9 reads both operands as unsigned and returns their difference as a signed lane. The difference clamps to the signed maximum or the signed minimum.
- R7: Opcode 10 (signed) and opcode 11 (unsigned) give the truncating mean (ws AND wt) + ((ws XOR wt) >> 1). The shift is arithmetic for opcode 10 and logical for opcode 11.
- R8: Opcode 12 (signed) and opcode 13 (unsigned) give the rounding mean (ws OR wt) - ((ws XOR wt) >> 1). They follow the same rule for the shift.
- R9: Opcode 14 returns the absolute value of the wrapped difference ws-wt. Opcode 15 returns the larger unsigned operand minus the smaller one.
- R10: Opcodes 16 to 31 are illegal. They drive an all-zero result and set `illegal_o`, and a legal opcode clears the flag again.
- R11: `valid_o` is high in exactly the cycle after each accepted `start_i`. `res_o` and `illegal_o` change only when a start is accepted.
- R12: While `rst_n` is low, `res_o`, `valid_o` and `illegal_o` are zero. A start is honoured from the third rising clock edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| start_i | input | 1 | Accept the operation presented this cycle |
| op_i | input | 5 | Operation code |
| fmt_i | input | 2 | Lane width code |
| ws_i | input | 128 | First operand vector |
| wt_i | input | 128 | Second operand vector |
| res_o | output | 128 | Registered lane results |
| valid_o | output | 1 | Result is new this cycle |
| illegal_o | output | 1 | Last accepted opcode was undefined |

## Verification
Every result, including the illegal flag and the zeroed vector, is due on the first rising edge after the start edge. The bench drives each start at a falling edge and compares `res_o`, `valid_o` and `illegal_o` at the next falling edge, which lies half a period after that capture edge. A further falling-edge sample confirms that `valid_o` has dropped and that `res_o` has held while new operands sit on the inputs without a start. Stimulus begins only after the two-edge reset release has completed.

// File: rtl/vsat_pkg.sv
package vsat_pkg;

  localparam int unsigned VEC_W  = 128;
  localparam int unsigned BASE_W = 8;
  localparam int unsigned N_FMT  = 4;
  localparam int unsigned OP_W   = 5;
  localparam int unsigned FMT_W  = $clog2(N_FMT);

  typedef enum logic [OP_W-1:0] {
    OP_ADD        = 5'd0,
    OP_SUB        = 5'd1,
    OP_MAGSUM     = 5'd2,
    OP_MAGSUM_SAT = 5'd3,
    OP_ADD_SATS   = 5'd4,
    OP_ADD_SATU   = 5'd5,
    OP_SUB_SATS   = 5'd6,
    OP_SUB_SATU   = 5'd7,
    OP_SUB_UMS    = 5'd8,
    OP_SUB_UUS    = 5'd9,
    OP_AVG_S      = 5'd10,
    OP_AVG_U      = 5'd11,
    OP_AVGR_S     = 5'd12,
    OP_AVGR_U     = 5'd13,
    OP_ADIFF_S    = 5'd14,
    OP_ADIFF_U    = 5'd15
  } vsat_op_e;

  localparam int unsigned N_OPS = 16;

endpackage

// File: rtl/vsat_lane.sv
module vsat_lane
  import vsat_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  vsat_op_e       op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   y_o
);

  localparam int unsigned G = W + 2;
  localparam logic signed [G-1:0] SMAX_G = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [G-1:0] SMIN_G = {3'b111, {(W-1){1'b0}}};
  localparam logic signed [G-1:0] UMAX_G = {2'b00, {W{1'b1}}};
  localparam logic [W:0]          SMAX_M = {2'b00, {(W-1){1'b1}}};
  localparam logic [W-1:0]        ONE_W  = {{(W-1){1'b0}}, 1'b1};

  // guarded operands
  logic signed [G-1:0] a_s, b_s, a_u, b_u;
  logic signed [G-1:0] sum_s, dif_s, sum_u, dif_u, dif_ums;
  logic [W-1:0]        mag_a, mag_b, hx, hx_s, hx_u, dw, adiff_s, adiff_u;
  logic [W:0]          mag_sum;

  function automatic logic [W-1:0] clamp_s(input logic signed [G-1:0] x);
    if (x > SMAX_G)      return SMAX_G[W-1:0];
    else if (x < SMIN_G) return SMIN_G[W-1:0];
    else                 return x[W-1:0];
  endfunction

  function automatic logic [W-1:0] clamp_u(input logic signed [G-1:0] x);
    if (x[G-1])          return '0;
    else if (x > UMAX_G) return '1;
    else                 return x[W-1:0];
  endfunction

  assign a_s = {{2{a_i[W-1]}}, a_i};
  assign b_s = {{2{b_i[W-1]}}, b_i};
  assign a_u = {2'b00, a_i};
  assign b_u = {2'b00, b_i};

  assign sum_s   = a_s + b_s;
  assign dif_s   = a_s - b_s;
  assign sum_u   = a_u + b_u;
  assign dif_u   = a_u - b_u;
  assign dif_ums = a_u - b_s;

  assign mag_a   = a_i[W-1] ? (~a_i + ONE_W) : a_i;
  assign mag_b   = b_i[W-1] ? (~b_i + ONE_W) : b_i;
  assign mag_sum = {1'b0, mag_a} + {1'b0, mag_b};

  assign hx   = a_i ^ b_i;
  assign hx_s = {hx[W-1], hx[W-1:1]};
  assign hx_u = {1'b0, hx[W-1:1]};

  assign dw      = a_i - b_i;
  assign adiff_s = dw[W-1] ? (~dw + ONE_W) : dw;
  assign adiff_u = (a_i > b_i) ? (a_i - b_i) : (b_i - a_i);

  always_comb begin
    unique case (op_i)
      OP_ADD:        y_o = a_i + b_i;
      OP_SUB:        y_o = a_i - b_i;
      OP_MAGSUM:     y_o = mag_sum[W-1:0];
      OP_MAGSUM_SAT: y_o = (mag_sum > SMAX_M) ? SMAX_G[W-1:0] : mag_sum[W-1:0];
      OP_ADD_SATS:   y_o = clamp_s(sum_s);
      OP_ADD_SATU:   y_o = clamp_u(sum_u);
      OP_SUB_SATS:   y_o = clamp_s(dif_s);
      OP_SUB_SATU:   y_o = clamp_u(dif_u);
      OP_SUB_UMS:    y_o = clamp_u(dif_ums);
      OP_SUB_UUS:    y_o = clamp_s(dif_u);
      OP_AVG_S:      y_o = (a_i & b_i) + hx_s;
      OP_AVG_U:      y_o = (a_i & b_i) + hx_u;
      OP_AVGR_S:     y_o = (a_i | b_i) - hx_s;
      OP_AVGR_U:     y_o = (a_i | b_i) - hx_u;
      OP_ADIFF_S:    y_o = adiff_s;
      OP_ADIFF_U:    y_o = adiff_u;
      default:       y_o = '0;
    endcase
  end

endmodule

// File: rtl/vsat_slice.sv
module vsat_slice
  import vsat_pkg::*;
#(
  parameter int unsigned VW = 128,
  parameter int unsigned W  = 8
) (
  input  vsat_op_e        op_i,
  input  logic [VW-1:0]   a_i,
  input  logic [VW-1:0]   b_i,
  output logic [VW-1:0]   y_o
);

  localparam int unsigned N_LANE = VW / W;

  for (genvar l = 0; l < N_LANE; l++) begin : g_lane
    vsat_lane #(.W(W)) u_lane (
      .op_i (op_i),
      .a_i  (a_i[l*W +: W]),
      .b_i  (b_i[l*W +: W]),
      .y_o  (y_o[l*W +: W])
    );
  end

endmodule

// File: rtl/vsat_adder.sv
module vsat_adder
  import vsat_pkg::*;
#(
  parameter int unsigned VW = VEC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [OP_W-1:0]      op_i,
  input  logic [FMT_W-1:0]     fmt_i,
  input  logic [VW-1:0]        ws_i,
  input  logic [VW-1:0]        wt_i,
  output logic [VW-1:0]        res_o,
  output logic                 valid_o,
  output logic                 illegal_o
);

  // reset: asynchronous assert, two-flop synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // datapath: one slice per lane width
  vsat_op_e      op_e;
  logic          op_bad;
  logic [VW-1:0] fmt_res [N_FMT];
  logic [VW-1:0] sel_res;

  assign op_e   = vsat_op_e'(op_i);
  assign op_bad = (op_i >= OP_W'(N_OPS));

  for (genvar f = 0; f < N_FMT; f++) begin : g_fmt
    vsat_slice #(.VW(VW), .W(BASE_W << f)) u_slice (
      .op_i (op_e),
      .a_i  (ws_i),
      .b_i  (wt_i),
      .y_o  (fmt_res[f])
    );
  end

  assign sel_res = fmt_res[fmt_i];

  // next state
  logic [VW-1:0] res_d;
  logic          valid_d, ill_d, upd_en;

  always_comb begin
    upd_en  = start_i;
    valid_d = start_i;
    ill_d   = op_bad;
    res_d   = op_bad ? '0 : sel_res;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_o     <= '0;
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_d;
      if (upd_en) begin
        res_o     <= res_d;
        illegal_o <= ill_d;
      end
    end
  end

endmodule

// File: rtl/vsat_adder_chk.sv
module vsat_adder_chk
  import vsat_pkg::*;
#(
  parameter int unsigned VW = VEC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [OP_W-1:0]   op_i,
  input logic [FMT_W-1:0]  fmt_i,
  input logic [VW-1:0]     ws_i,
  input logic [VW-1:0]     wt_i,
  input logic [VW-1:0]     res_o,
  input logic              valid_o,
  input logic              illegal_o
);

  // R11
  valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);

  // R11
  valid_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o);

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(res_o) && $stable(illegal_o));

  // R10
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i >= OP_W'(N_OPS)) |=> illegal_o && res_o == '0);

  // R10
  legal_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i < OP_W'(N_OPS)) |=> !illegal_o);

  // R1
  add_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i == OP_W'(OP_ADD) && wt_i == '0) |=> res_o == $past(ws_i));

  // R9
  adiff_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && op_i == OP_W'(OP_ADIFF_U) && ws_i == wt_i) |=> res_o == '0);

  // R12
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> !valid_o && !illegal_o && res_o == '0);

  logic unused_fmt;
  assign unused_fmt = ^fmt_i;

endmodule

bind vsat_adder vsat_adder_chk #(.VW(VW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .start_i   (start_i),
  .op_i      (op_i),
  .fmt_i     (fmt_i),
  .ws_i      (ws_i),
  .wt_i      (wt_i),
  .res_o     (res_o),
  .valid_o   (valid_o),
  .illegal_o (illegal_o)
);

// File: tb/vsat_adder_bench.sv
module vsat_adder_bench;
  import vsat_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 33;

  typedef struct packed {
    vsat_op_e     op;
    logic [1:0]   fmt;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] e;
    logic [7:0]   req;
  } vec_t;

  localparam vec_t TBL [N_VEC] = '{
    // R1 wrapping add/sub, lane independence
    '{OP_ADD, 2'd0, {16{8'h7F}}, {16{8'h01}}, {16{8'h80}}, 8'd1},
    '{OP_SUB, 2'd0, {16{8'h00}}, {16{8'h01}}, {16{8'hFF}}, 8'd1},
    '{OP_ADD, 2'd0, {8{16'h80FF}}, {8{16'h8001}}, {8{16'h0000}}, 8'd1},
    '{OP_ADD, 2'd1, {8{16'h80FF}}, {8{16'h8001}}, {8{16'h0100}}, 8'd1},
    '{OP_ADD, 2'd2, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, {4{32'h0}}, 8'd1},
    // R2 magnitude sums
    '{OP_MAGSUM, 2'd0, {16{8'h80}}, {16{8'h80}}, {16{8'h00}}, 8'd2},
    '{OP_MAGSUM_SAT, 2'd0, {16{8'h80}}, {16{8'h80}}, {16{8'h7F}}, 8'd2},
    '{OP_MAGSUM_SAT, 2'd1, {8{16'h0005}}, {8{16'hFFFD}}, {8{16'h0008}}, 8'd2},
    // R3 signed clamped add/sub
    '{OP_ADD_SATS, 2'd0, {16{8'h70}}, {16{8'h70}}, {16{8'h7F}}, 8'd3},
    '{OP_ADD_SATS, 2'd0, {16{8'h90}}, {16{8'h90}}, {16{8'h80}}, 8'd3},
    '{OP_ADD_SATS, 2'd0, {16{8'h10}}, {16{8'hF0}}, {16{8'h00}}, 8'd3},
    '{OP_SUB_SATS, 2'd0, {16{8'h80}}, {16{8'h01}}, {16{8'h80}}, 8'd3},
    '{OP_SUB_SATS, 2'd0, {16{8'h7F}}, {16{8'hFF}}, {16{8'h7F}}, 8'd3},
    '{OP_ADD_SATS, 2'd3, {2{64'h7FFF_FFFF_FFFF_FFFF}}, {2{64'h1}}, {2{64'h7FFF_FFFF_FFFF_FFFF}}, 8'd3},
    // R4 unsigned clamped add/sub
    '{OP_ADD_SATU, 2'd0, {16{8'hF0}}, {16{8'h20}}, {16{8'hFF}}, 8'd4},
    '{OP_ADD_SATU, 2'd0, {16{8'h10}}, {16{8'h20}}, {16{8'h30}}, 8'd4},
    '{OP_SUB_SATU, 2'd0, {16{8'h10}}, {16{8'h20}}, {16{8'h00}}, 8'd4},
    '{OP_SUB_SATU, 2'd0, {16{8'h20}}, {16{8'h10}}, {16{8'h10}}, 8'd4},
    '{OP_ADD_SATU, 2'd3, {2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'h1}}, {2{64'hFFFF_FFFF_FFFF_FFFF}}, 8'd4},
    // R5 unsigned minus signed
    '{OP_SUB_UMS, 2'd0, {16{8'hF0}}, {16{8'h80}}, {16{8'hFF}}, 8'd5},
    '{OP_SUB_UMS, 2'd0, {16{8'h10}}, {16{8'h20}}, {16{8'h00}}, 8'd5},
    '{OP_SUB_UMS, 2'd2, {4{32'h0000_0010}}, {4{32'hFFFF_FFF0}}, {4{32'h0000_0020}}, 8'd5},
    // R6 unsigned minus unsigned, signed result
    '{OP_SUB_UUS, 2'd0, {16{8'hFF}}, {16{8'h00}}, {16{8'h7F}}, 8'd6},
    '{OP_SUB_UUS, 2'd0, {16{8'h00}}, {16{8'hFF}}, {16{8'h80}}, 8'd6},
    '{OP_SUB_UUS, 2'd0, {16{8'h03}}, {16{8'h05}}, {16{8'hFE}}, 8'd6},
    '{OP_SUB_UUS, 2'd3, {2{64'h0}}, {2{64'hFFFF_FFFF_FFFF_FFFF}}, {2{64'h8000_0000_0000_0000}}, 8'd6},
    // R7 truncating means
    '{OP_AVG_S, 2'd0, {16{8'hFF}}, {16{8'h00}}, {16{8'hFF}}, 8'd7},
    '{OP_AVG_U, 2'd0, {16{8'hFF}}, {16{8'h00}}, {16{8'h7F}}, 8'd7},
    '{OP_AVG_S, 2'd1, {8{16'h7FFF}}, {8{16'h7FFF}}, {8{16'h7FFF}}, 8'd7},
    // R8 rounding means
    '{OP_AVGR_S, 2'd0, {16{8'hFF}}, {16{8'h00}}, {16{8'h00}}, 8'd8},
    '{OP_AVGR_U, 2'd0, {16{8'hFF}}, {16{8'h00}}, {16{8'h80}}, 8'd8},
    // R9 absolute differences
    '{OP_ADIFF_S, 2'd0, {16{8'h64}}, {16{8'h9C}}, {16{8'h38}}, 8'd9},
    '{OP_ADIFF_U, 2'd0, {16{8'h05}}, {16{8'hFA}}, {16{8'hF5}}, 8'd9}
  };

  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [4:0]   op_i;
  logic [1:0]   fmt_i;
  logic [127:0] ws_i, wt_i, res_o;
  logic         valid_o, illegal_o;

  int checks   = 0;
  int failures = 0;
  logic         done = 1'b0;

  vsat_adder u_vsat_adder (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .op_i      (op_i),
    .fmt_i     (fmt_i),
    .ws_i      (ws_i),
    .wt_i      (wt_i),
    .res_o     (res_o),
    .valid_o   (valid_o),
    .illegal_o (illegal_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [127:0] act, input logic [127:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic [1:0] fmt,
                       input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    start_i = 1'b1;
    op_i    = op;
    fmt_i   = fmt;
    ws_i    = a;
    wt_i    = b;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    start_i = 1'b0;
    op_i    = '0;
    fmt_i   = '0;
    ws_i    = '0;
    wt_i    = '0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    // R12 outputs held at zero in reset
    check(res_o, '0, 12);
    check({126'd0, valid_o, illegal_o}, '0, 12);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < N_VEC; i++) begin
      issue(5'(TBL[i].op), TBL[i].fmt, TBL[i].a, TBL[i].b);
      check(res_o, TBL[i].e, int'(TBL[i].req));
      // R11 valid in the cycle after start
      check({127'd0, valid_o}, 128'd1, 11);
    end

    // R11 valid drops and result holds without start
    ws_i = {16{8'h55}};
    wt_i = {16{8'h22}};
    op_i = 5'(OP_SUB);
    @(negedge clk);
    check({127'd0, valid_o}, 128'd0, 11);
    check(res_o, {16{8'hF5}}, 11);

    // R10 illegal opcode
    issue(5'd20, 2'd0, {16{8'h12}}, {16{8'h34}});
    check(res_o, '0, 10);
    check({127'd0, illegal_o}, 128'd1, 10);
    check({127'd0, valid_o}, 128'd1, 10);
    issue(5'd31, 2'd3, '1, '1);
    check(res_o, '0, 10);
    // R10 legal opcode clears flag
    issue(5'(OP_ADD), 2'd0, {16{8'h01}}, {16{8'h02}});
    check({127'd0, illegal_o}, 128'd0, 10);
    check(res_o, {16{8'h03}}, 10);

    // R12 asynchronous reset mid-run, then restart after release
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(res_o, '0, 12);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    issue(5'(OP_ADD), 2'd1, {8{16'h1000}}, {8{16'h0234}});
    check(res_o, {8{16'h1234}}, 12);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule